// File: doc/BRIEF.md
# Boot Remap and Abort Decoder

This block sits between a 32-bit processor and its memory system and decides, for every access, which target answers it. While the reset input is held low it samples a boot-mode pin on each clock edge, and it keeps the level seen at the last edge before reset is released as the data width of the boot memory. After reset the lowest megabyte of the address space goes to the external boot device on chip select 0, so the processor can fetch its reset vector from nonvolatile memory.

Software writes a one to a remap command bit in a control register to move the internal 8 KB SRAM to address zero, so that the exception vectors can be rewritten. Remapping also opens chip selects 1 to 7. Only a reset can undo it. For each valid access the block raises exactly one of a chip select, the SRAM select, the peripheral select or an abort. The abort is combinational, so it can be returned to the processor in the same cycle as the address. For SRAM accesses it also produces byte lane enables from the access size and the low address bits.

Top module: `bootMapDecoder`

## Requirements
- R1: On every rising clock edge while rstN is low, boot8Bit loads bootPin. The value loaded at the last such edge holds unchanged until the next reset. A 1 means an 8-bit boot device and a 0 means a 16-bit boot device. A reset of only a few cycles still keeps the last level it sampled.
- R2: After reset, remapped is 0. Any valid access with accAddr[31:20] == 0 then sets csSel[0].
- R3: A write with regWrEn=1, regAddr=0x00 and regWrData[0]=1 makes remapped read 1 from the next clock cycle. A write to any other offset, or with regWrData[0]=0, leaves remapped unchanged.
- R4: Once remapped is 1, no register write clears it. Only driving rstN low returns it to 0.
- R5: Chip select k (k = 0..7) owns the 1 MB window with accAddr[31:20] == 0x010 + k and drives csSel[k]. The window of chip select 0 is always open. The windows of chip selects 1 to 7 are open only while remapped is 1, and while it is 0 an access to them aborts.
- R6: While remapped is 1, a valid access with accAddr[31:20] == 0 sets sramSel. It does not set csSel[0] and does not abort. The 8 KB SRAM image repeats across that megabyte.
- R7: A valid access with accAddr[31:22] all ones sets periphSel and never aborts, whether or not a peripheral is defined at that address.
- R8: Every other valid address, in the external region and outside an open chip select window, raises abort in the same cycle as the address. With accValid=0, all select outputs and abort are 0.
- R9: sramByteEn is 0 unless sramSel is 1. accSize 0 (byte) sets bit accAddr[1:0]. accSize 1 (half-word) gives 0011 when accAddr[1]=0 and 1100 when accAddr[1]=1. accSize 2 (word) gives 1111. accSize 3 gives 0000.
- R10: At most one of the csSel bits, sramSel, periphSel and abort is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; the boot pin is sampled while it is low |
| bootPin | input | 1 | Boot-width select pin (1 = 8-bit, 0 = 16-bit) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| accValid | input | 1 | Access-valid strobe |
| accAddr | input | 32 | Access byte address |
| accSize | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| remapped | output | 1 | SRAM is mapped at address zero |
| boot8Bit | output | 1 | Latched boot width (1 = 8-bit) |
| csSel | output | 8 | One-hot external chip selects |
| sramSel | output | 1 | Internal SRAM selected |
| sramByteEn | output | 4 | SRAM byte lane enables |
| periphSel | output | 1 | Internal peripheral region selected |
| abort | output | 1 | Access to an undefined external address |

## Verification
Random addresses are drawn by class: the low megabyte, the eight chip select windows, the peripheral region, the pages on either side of the window block, and fully random values. Each class is applied both before and after remap, which separates the boot map from the remapped map and shows whether chip selects 1 to 7 are held closed. Directed edge addresses at each region boundary, together with every size and alignment pair, test the abort limits and the byte lanes. Writes to a wrong offset, writes with bit 0 clear, and a short second reset with the other pin level check that remap is one-way and that the boot width is taken from the last edge of reset.

// File: rtl/bmdPkg.sv
package bmdPkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  // state that the control module hands to the address datapath
  typedef struct packed {
    logic remapOn;
    logic boot8;
  } ctrlStrobes_t;

endpackage

// File: rtl/bmdControl.sv
module bmdControl
  import bmdPkg::*;
#(
  parameter int unsigned REG_AW       = 8,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned REMAP_OFFSET = 0,
  parameter int unsigned REMAP_BIT    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootPin,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output ctrlStrobes_t      strobes
);

  localparam logic [REG_AW-1:0] REMAP_ADDR = REG_AW'(REMAP_OFFSET);

  logic remapQ;
  logic boot8Q;
  logic remapHit;

  assign remapHit = regWrEn && (regAddr == REMAP_ADDR) && regWrData[REMAP_BIT];

  // one-way flag: only the reset input clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) remapQ <= 1'b0;
    else if (remapHit) remapQ <= 1'b1;
  end

  // boot width follows the pin on every edge while reset is held; the
  // final edge before release decides
  always_ff @(posedge clk) begin
    if (!rstN) boot8Q <= bootPin;
  end

  assign strobes.remapOn = remapQ;
  assign strobes.boot8   = boot8Q;

  assert_remap_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == REMAP_ADDR && regWrData[REMAP_BIT]) |=> remapQ);

  assert_remap_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(remapQ));

  assert_boot_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(boot8Q));

endmodule

// File: rtl/bmdDecode.sv
module bmdDecode
  import bmdPkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CS_N        = 8,
  parameter int unsigned WIN_LOG2    = 20,
  parameter int unsigned PERIPH_LOG2 = 22,
  parameter logic [31:0] EXT_BASE    = 32'h0100_0000,
  parameter int unsigned LANES       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  output logic [CS_N-1:0]   csSel,
  output logic              sramSel,
  output logic [LANES-1:0]  sramByteEn,
  output logic              periphSel,
  output logic              abort
);

  localparam int unsigned PAGE_W  = ADDR_W - WIN_LOG2;
  localparam int unsigned PTOP_W  = ADDR_W - PERIPH_LOG2;
  localparam int unsigned LANE_W  = $clog2(LANES);
  localparam logic [PAGE_W-1:0] EXT_PAGE = PAGE_W'(EXT_BASE >> WIN_LOG2);

  logic [PAGE_W-1:0] page;
  logic              lowHit;
  logic              periphHit;
  logic [CS_N-1:0]   csWin;
  logic [CS_N-1:0]   csOpen;
  logic [LANES-1:0]  laneMask;

  assign page      = accAddr[ADDR_W-1:WIN_LOG2];
  assign lowHit    = (page == '0);
  assign periphHit = &accAddr[ADDR_W-1:PERIPH_LOG2];

  for (genvar k = 0; k < CS_N; k++) begin : g_cs
    assign csWin[k] = (page == EXT_PAGE + PAGE_W'(k));
    if (k == 0) begin : g_boot
      // boot device: low megabyte before remap, own window always
      assign csOpen[k] = csWin[k];
      assign csSel[k]  = accValid && (csWin[k] || (lowHit && !strobes.remapOn));
    end else begin : g_ext
      assign csOpen[k] = csWin[k] && strobes.remapOn;
      assign csSel[k]  = accValid && csOpen[k];
    end
  end

  assign sramSel   = accValid && lowHit && strobes.remapOn;
  assign periphSel = accValid && periphHit;
  assign abort     = accValid && !lowHit && !periphHit && !(|csOpen);

  always_comb begin
    unique case (accSize_e'(accSize))
      SZ_BYTE: laneMask = LANES'(1) << accAddr[LANE_W-1:0];
      SZ_HALF: laneMask = accAddr[1] ? LANES'(4'b1100) : LANES'(4'b0011);
      SZ_WORD: laneMask = '1;
      default: laneMask = '0;
    endcase
  end

  assign sramByteEn = sramSel ? laneMask : '0;

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({csSel, sramSel, periphSel, abort}));

  assert_closed_cs_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.remapOn |-> (csSel[CS_N-1:1] == '0));

  assert_periph_no_abort_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && (&accAddr[ADDR_W-1:PTOP_W'(0)+PERIPH_LOG2])) |-> !abort);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !(abort || sramSel || periphSel || (|csSel)));

  assert_lanes_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    !sramSel |-> (sramByteEn == '0));

endmodule

// File: rtl/bootMapDecoder.sv
module bootMapDecoder
  import bmdPkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned REG_AW       = 8,
  parameter int unsigned CS_N         = 8,
  parameter int unsigned WIN_LOG2     = 20,
  parameter int unsigned PERIPH_LOG2  = 22,
  parameter logic [31:0] EXT_BASE     = 32'h0100_0000,
  parameter int unsigned REMAP_OFFSET = 0,
  parameter int unsigned REMAP_BIT    = 0,
  parameter int unsigned LANES        = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootPin,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  output logic              remapped,
  output logic              boot8Bit,
  output logic [CS_N-1:0]   csSel,
  output logic              sramSel,
  output logic [LANES-1:0]  sramByteEn,
  output logic              periphSel,
  output logic              abort
);

  ctrlStrobes_t strobes;

  bmdControl #(
    .REG_AW(REG_AW), .DATA_W(DATA_W),
    .REMAP_OFFSET(REMAP_OFFSET), .REMAP_BIT(REMAP_BIT)
  ) i_control (
    .clk(clk), .rstN(rstN), .bootPin(bootPin),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strobes(strobes)
  );

  bmdDecode #(
    .ADDR_W(ADDR_W), .CS_N(CS_N), .WIN_LOG2(WIN_LOG2),
    .PERIPH_LOG2(PERIPH_LOG2), .EXT_BASE(EXT_BASE), .LANES(LANES)
  ) i_decode (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .accValid(accValid), .accAddr(accAddr), .accSize(accSize),
    .csSel(csSel), .sramSel(sramSel), .sramByteEn(sramByteEn),
    .periphSel(periphSel), .abort(abort)
  );

  assign remapped = strobes.remapOn;
  assign boot8Bit = strobes.boot8;

endmodule

// File: tb/test_bootMapDecoder.sv
`timescale 1ns/1ps
module test_bootMapDecoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bootPin = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic [1:0]  accSize = '0;
  logic        remapped, boot8Bit, sramSel, periphSel, abort;
  logic [7:0]  csSel;
  logic [3:0]  sramByteEn;

  int vecCount = 0;
  int badCount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bootMapDecoder i_bootMapDecoder (
    .clk(clk), .rstN(rstN), .bootPin(bootPin),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .accValid(accValid), .accAddr(accAddr), .accSize(accSize),
    .remapped(remapped), .boot8Bit(boot8Bit), .csSel(csSel),
    .sramSel(sramSel), .sramByteEn(sramByteEn),
    .periphSel(periphSel), .abort(abort)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      badCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {csSel, sramSel, periphSel, abort, sramByteEn}
  function automatic logic [14:0] refModel(logic [31:0] a, logic [1:0] sz,
                                           logic v, logic rm);
    logic [7:0]  cs = '0;
    logic        sr = 1'b0, pe = 1'b0, ab = 1'b0;
    logic [3:0]  be = '0;
    logic [11:0] pg = a[31:20];
    if (v) begin
      if (pg == 12'h000) begin
        if (rm) sr = 1'b1; else cs[0] = 1'b1;
      end else if (a[31:22] == 10'h3FF) pe = 1'b1;
      else if (pg >= 12'h010 && pg <= 12'h017 && (pg == 12'h010 || rm)) cs[pg[2:0]] = 1'b1;
      else ab = 1'b1;
      if (sr) begin
        case (sz)
          2'd0: be = 4'b0001 << a[1:0];
          2'd1: be = a[1] ? 4'b1100 : 4'b0011;
          2'd2: be = 4'b1111;
          default: be = 4'b0000;
        endcase
      end
    end
    return {cs, sr, pe, ab, be};
  endfunction

  task automatic applyAcc(string req, logic [31:0] a, logic [1:0] sz, logic v, logic rm);
    @(negedge clk);
    accAddr = a; accSize = sz; accValid = v;
    #1;
    check(req, {17'd0, csSel, sramSel, periphSel, abort, sramByteEn},
          {17'd0, refModel(a, sz, v, rm)});
  endtask

  task automatic regWrite(logic [7:0] off, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = off; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  function automatic logic [31:0] randAddr();
    logic [31:0] r = $urandom;
    case ($urandom % 5)
      0: return {12'h000, r[19:0]};
      1: return {12'h010 + 12'($urandom % 8), r[19:0]};
      2: return {10'h3FF, r[21:0]};
      3: return {(r[31] ? 12'h018 : 12'h00F), r[19:0]};
      default: return r;
    endcase
  endfunction

  task automatic randomBurst(string req, int n, logic rm);
    for (int i = 0; i < n; i++)
      applyAcc(req, randAddr(), 2'($urandom % 4), ($urandom % 8) != 0, rm);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        badCount++;
        $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: pin high for most of reset, low at the final edge
    bootPin = 1'b1;
    repeat (12) @(negedge clk);
    bootPin = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    bootPin = 1'b1;
    #1;
    check("R1 boot width from last reset edge", 32'(boot8Bit), 32'd0);
    check("R2 remap clear after reset", 32'(remapped), 32'd0);
    repeat (3) @(negedge clk);
    check("R1 boot width held after reset", 32'(boot8Bit), 32'd0);

    // R2 / R5 / R7 / R8 directed, boot map
    applyAcc("R2 low region to cs0", 32'h0000_0000, 2'd2, 1'b1, 1'b0);
    applyAcc("R2 top of low MB", 32'h000F_FFFF, 2'd0, 1'b1, 1'b0);
    applyAcc("R8 page above low MB", 32'h0010_0000, 2'd2, 1'b1, 1'b0);
    applyAcc("R5 cs0 window", 32'h0100_0000, 2'd2, 1'b1, 1'b0);
    applyAcc("R5 cs3 closed before remap", 32'h0130_0004, 2'd2, 1'b1, 1'b0);
    applyAcc("R7 periph base", 32'hFFC0_0000, 2'd2, 1'b1, 1'b0);
    applyAcc("R8 below periph", 32'hFFBF_FFFF, 2'd2, 1'b1, 1'b0);
    applyAcc("R8 idle strobe", 32'h0180_0000, 2'd2, 1'b0, 1'b0);
    randomBurst("R10 random boot map", 400, 1'b0);

    // R3: writes that must not remap
    regWrite(8'h04, 32'h0000_0001);
    #1; check("R3 wrong offset ignored", 32'(remapped), 32'd0);
    applyAcc("R3 still boot map", 32'h0000_0100, 2'd2, 1'b1, 1'b0);
    regWrite(8'h00, 32'hFFFF_FFFE);
    #1; check("R3 bit0 clear ignored", 32'(remapped), 32'd0);
    regWrite(8'h00, 32'h0000_0001);
    #1; check("R3 remap set", 32'(remapped), 32'd1);
    regWrite(8'h00, 32'h0000_0000);
    #1; check("R4 remap not cleared by write", 32'(remapped), 32'd1);

    // R5 / R6 / R9 directed, remapped
    applyAcc("R6 low region to sram", 32'h0000_0000, 2'd2, 1'b1, 1'b1);
    applyAcc("R6 sram alias end of MB", 32'h000F_FFFE, 2'd1, 1'b1, 1'b1);
    applyAcc("R5 cs7 open", 32'h017F_FFFF, 2'd2, 1'b1, 1'b1);
    applyAcc("R8 past cs7", 32'h0180_0000, 2'd2, 1'b1, 1'b1);
    applyAcc("R7 periph top", 32'hFFFF_FFFF, 2'd0, 1'b1, 1'b1);
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        applyAcc("R9 lanes", 32'h0000_1F00 + 32'(o), 2'(s), 1'b1, 1'b1);
    randomBurst("R10 random remapped", 400, 1'b1);

    // R1 / R4: short reset with the pin high
    @(negedge clk);
    rstN = 1'b0; bootPin = 1'b1;
    #1; check("R4 reset clears remap", 32'(remapped), 32'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1; bootPin = 1'b0;
    #1; check("R1 short reset keeps sampled level", 32'(boot8Bit), 32'd1);
    applyAcc("R4 boot map after reset", 32'h0000_0040, 2'd2, 1'b1, 1'b0);
    applyAcc("R5 cs1 closed again", 32'h0110_0000, 2'd2, 1'b1, 1'b0);
    randomBurst("R10 random after reset", 200, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
    $finish;
  end

endmodule